// File: doc/BRIEF.md
# Miscellaneous Interrupt Aggregation Controller

This block merges thirty-two peripheral interrupt sources into one interrupt line for a parent controller. Each source is synchronised into the block's clock domain and recorded in a status word. A mask word chooses which sources may reach the parent. A source is pending when its status bit and its mask bit are both set. The parent line is raised while any source is pending.

Software uses a small word-wide register port. It reads the status word and the mask word, changes the mask with read-modify-write, and reads a helper word that gives the lowest-numbered pending source so the handler can serve sources in ascending order. A build-time parameter picks one of two status behaviours. In the level variant, status copies the synchronised source levels and cannot be written. In the latched variant, a status bit stays set after its source goes away. Software then clears it by writing back a word that has a zero in that position.

Top module: `misc_irq_aggregator`

## Requirements
- R1: Each source passes through a two-flop synchroniser and then a status flop. A source level driven before a rising edge shows in the status word after the third rising edge and not after the second.
- R2: The register offsets are fixed: status at byte offset 0, mask at byte offset 4, lowest-pending index at byte offset 8. A read at any other offset returns zero. Read data follows the address combinationally.
- R3: `parent_irq` goes high one rising edge after (status AND mask) becomes nonzero. It goes low one rising edge after that AND becomes zero.
- R4: A write to offset 4 stores the full 32-bit word into the mask at that edge, and later reads return that word.
- R5: In the latched variant, a status bit stays set after its source drops. A status write with a 1 in that position leaves it set. A write with a 0 in that position clears it.
- R6: In the latched variant, writing all zeros to status clears every bit whose source is inactive. A source that is active during the clearing write keeps its bit set.
- R7: In the level variant, status equals the synchronised source levels and writes to offset 0 have no effect. Clearing a mask bit is the only way to silence an active source.
- R8: The word at offset 8 carries the index of the lowest pending source in bits 4:0 and zeros elsewhere. When nothing is pending it reads 0x8000_0000 (bit 31 set, index 0).
- R9: After reset the status and mask read zero, the index word reads 0x8000_0000, and `parent_irq` is low.
- R10: The index word is read-only. A write to offset 8 changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 32 | Asynchronous interrupt source levels, one bit per source |
| reg_wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Byte offset of the register to read or write |
| reg_wr_data | input | 32 | Write data word |
| reg_rd_data | output | 32 | Read data word for `reg_addr` |
| parent_irq | output | 1 | Combined interrupt request to the parent controller |

## Verification
The assertions check on every cycle that the parent line follows the pending set one edge later and that the synchroniser delays each source by exactly two edges. They also check that the index output points at a set pending bit with no lower bit set, that a mask write is stored whole, and that latched status bits fall only under a clearing write while active sources always set theirs. Only the bench's scenarios can show the exact three-edge latency seen at the register port, the absence of effect from status writes in the level variant and from writes to the read-only offset, and the winning of an active source over a simultaneous clear. It runs randomised source, mask and clear-word patterns on both variants side by side against its own model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int SRC_COUNT = 32;
    localparam int IDX_W     = $clog2(SRC_COUNT);
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_INDEX  = 4'h8;

    typedef enum logic [1:0] {
        SEL_STATUS,
        SEL_MASK,
        SEL_INDEX,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic             none;
        logic [IDX_W-1:0] idx;
    } prio_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STATUS: return SEL_STATUS;
            OFS_MASK:   return SEL_MASK;
            OFS_INDEX:  return SEL_INDEX;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic prio_t lowest_set(input logic [SRC_COUNT-1:0] v);
        prio_t r;
        r.none = 1'b1;
        r.idx  = '0;
        for (int i = SRC_COUNT - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.none = 1'b0;
                r.idx  = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q, stage2_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            warm_q   <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        end
    end

    assign sync_out = stage2_q;

    // R1: two-edge synchroniser delay once both stages hold post-reset data
    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int W       = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_in,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_word,
    output logic [W-1:0] status_q
);
    generate
        if (LATCHED) begin : g_latched
            logic [W-1:0] keep;
            assign keep = clr_wr ? clr_word : '1;

            always_ff @(posedge clk) begin
                if (rst) status_q <= '0;
                else     status_q <= (status_q & keep) | sync_in;
            end

            // R5: without a write no latched bit falls
            assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
            // R5: after a write, every bit zero in the word and inactive is clear
            assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
                clr_wr |=> ((status_q & ~$past(clr_word) & ~$past(sync_in)) == '0));
            // R6: an active source always sets its bit, even under a clearing write
            assert_src_wins_R6: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((status_q & $past(sync_in)) == $past(sync_in)));
        end else begin : g_level
            logic unused_level_bits;
            assign unused_level_bits = ^{clr_wr, clr_word};

            always_ff @(posedge clk) begin
                if (rst) status_q <= '0;
                else     status_q <= sync_in;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_COUNT-1:0] pending,
    output prio_t                prio
);
    assign prio = lowest_set(pending);

    // R8: index points at a pending bit and no lower bit is pending
    assert_idx_lowest_R8: assert property (@(posedge clk) disable iff (rst)
        !prio.none |-> (pending[prio.idx] &&
            ((pending & ((SRC_COUNT'(1) << prio.idx) - SRC_COUNT'(1))) == '0)));
    // R8: the empty flag matches an empty pending set
    assert_idx_none_R8: assert property (@(posedge clk) disable iff (rst)
        prio.none |-> (pending == '0));

endmodule

// File: rtl/misc_irq_aggregator.sv
module misc_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter bit LATCHED_STATUS = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_COUNT-1:0] src_irq,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wr_data,
    output logic [31:0]          reg_rd_data,
    output logic                 parent_irq
);
    localparam int PAD_W = 31 - IDX_W;

    logic [SRC_COUNT-1:0] src_sync;
    logic [SRC_COUNT-1:0] status_q;
    logic [SRC_COUNT-1:0] mask_q;
    logic [SRC_COUNT-1:0] pending;
    logic                 parent_q;
    reg_sel_e             sel;
    prio_t                prio;

    assign sel = decode_addr(reg_addr);

    irq_sync #(.W(SRC_COUNT)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (src_irq),
        .sync_out (src_sync)
    );

    irq_status #(.W(SRC_COUNT), .LATCHED(LATCHED_STATUS)) u_status (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (src_sync),
        .clr_wr   (reg_wr_en && (sel == SEL_STATUS)),
        .clr_word (reg_wr_data),
        .status_q (status_q)
    );

    assign pending = status_q & mask_q;

    irq_prio_enc u_prio (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .prio    (prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            parent_q <= 1'b0;
        end else begin
            if (reg_wr_en && (sel == SEL_MASK)) mask_q <= reg_wr_data;
            parent_q <= |pending;
        end
    end

    assign parent_irq = parent_q;

    always_comb begin
        case (sel)
            SEL_STATUS: reg_rd_data = status_q;
            SEL_MASK:   reg_rd_data = mask_q;
            SEL_INDEX:  reg_rd_data = {prio.none, {PAD_W{1'b0}}, prio.idx};
            default:    reg_rd_data = '0;
        endcase
    end

    // R3: a pending source raises the parent line at the next edge
    assert_parent_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (|(status_q & mask_q)) |=> parent_irq);
    // R3: an empty pending set drops the parent line at the next edge
    assert_parent_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !(|(status_q & mask_q)) |=> !parent_irq);
    // R4: a mask write is stored as a whole word
    assert_mask_store_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == OFS_MASK) |=> (mask_q == $past(reg_wr_data)));
    // R10: writes elsewhere leave the mask alone
    assert_mask_keep_R10: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_addr == OFS_MASK) |=> $stable(mask_q));

endmodule

// File: tb/misc_irq_aggregator_tb.sv
module misc_irq_aggregator_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_irq = '0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] rd_lat, rd_lvl;
    logic        irq_lat, irq_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_stat_lat, m_stat_lvl, m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    misc_irq_aggregator #(.LATCHED_STATUS(1'b1)) u_dut (
        .clk(clk), .rst(rst), .src_irq(src_irq), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_data(rd_lat), .parent_irq(irq_lat));

    misc_irq_aggregator #(.LATCHED_STATUS(1'b0)) u_dut_level (
        .clk(clk), .rst(rst), .src_irq(src_irq), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_data(rd_lvl), .parent_irq(irq_lvl));

    function automatic logic [31:0] exp_index(input logic [31:0] p);
        for (int i = 0; i < 32; i++)
            if (p[i]) return 32'(i);
        return 32'h8000_0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a);
        reg_addr = a;
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        rd(4'h0);
        check({tag, " R5 status latched"}, rd_lat, m_stat_lat);
        check({tag, " R7 status level"}, rd_lvl, m_stat_lvl);
        rd(4'h4);
        check({tag, " R4 mask"}, rd_lat, m_mask);
        rd(4'h8);
        check({tag, " R8 index latched"}, rd_lat, exp_index(m_stat_lat & m_mask));
        check({tag, " R8 index level"}, rd_lvl, exp_index(m_stat_lvl & m_mask));
        check({tag, " R3 parent latched"}, 32'(irq_lat), 32'(|(m_stat_lat & m_mask)));
        check({tag, " R3 parent level"}, 32'(irq_lvl), 32'(|(m_stat_lvl & m_mask)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst = 1'b0;
        step(1);
        m_stat_lat = '0; m_stat_lvl = '0; m_mask = '0;
        check_all("R9 reset");
        rd(4'hC);
        check("R2 unmapped read", rd_lat, 32'h0);

        // R1: three-edge latency to the status word
        src_irq = 32'h0000_0080;
        step(2);
        rd(4'h0);
        check("R1 not yet after two edges", rd_lat, 32'h0);
        step(1);
        rd(4'h0);
        check("R1 visible after third edge latched", rd_lat, 32'h80);
        check("R1 visible after third edge level", rd_lvl, 32'h80);

        // R3: parent timing relative to a mask write
        wr(4'h4, 32'h80);
        check("R3 parent still low at mask edge", 32'(irq_lat), 32'h0);
        step(1);
        check("R3 parent high one edge later", 32'(irq_lat), 32'h1);
        check("R3 parent high level", 32'(irq_lvl), 32'h1);
        wr(4'h4, 32'h0);
        check("R3 parent still high at unmask edge", 32'(irq_lat), 32'h1);
        step(1);
        check("R7 mask clear silences level", 32'(irq_lvl), 32'h0);
        check("R3 parent low latched", 32'(irq_lat), 32'h0);

        // R5: latch holds after source drops; ones keep, zeros clear
        src_irq = 32'h0;
        step(4);
        m_stat_lat = 32'h80; m_stat_lvl = 32'h0;
        check_all("R5 hold");
        wr(4'h0, 32'hFFFF_FFFF);
        check_all("R5 write ones keeps");
        wr(4'h0, 32'hFFFF_FF7F);
        m_stat_lat = 32'h0;
        check_all("R5 zero bit clears");

        // R6: all-zero clear while one source stays active
        src_irq = 32'h0000_0020;
        step(4);
        src_irq = 32'h0000_0021;
        step(1);
        src_irq = 32'h0000_0020;
        step(4);
        m_stat_lat = 32'h21; m_stat_lvl = 32'h20;
        wr(4'h0, 32'h0);
        step(1);
        m_stat_lat = 32'h20;
        check_all("R6 active source wins");

        // R7: status write ignored in level variant
        wr(4'h0, 32'h0);
        rd(4'h0);
        check("R7 level status write ignored", rd_lvl, 32'h20);

        // R10: index word read-only
        wr(4'h4, 32'h0000_0030);
        m_mask = 32'h30;
        wr(4'h8, 32'hFFFF_FFFF);
        check_all("R10 index write ignored");

        // Randomised patterns on both variants
        for (int it = 0; it < 60; it++) begin
            logic [31:0] s, mk, cw;
            s  = $urandom() & $urandom();
            mk = $urandom();
            cw = $urandom() | $urandom();
            src_irq = s;
            step(4);
            m_stat_lat = m_stat_lat | s;
            m_stat_lvl = s;
            wr(4'h4, mk);
            m_mask = mk;
            if (it % 3 != 0) begin
                wr(4'h0, cw);
                m_stat_lat = (m_stat_lat & cw) | s;
            end
            step(1);
            check_all("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule